// File: doc/BRIEF.md
# Triple Match/Overflow Timer

A memory-mapped timer peripheral holding three independent 32-bit timers. Each timer owns a counter, a reload value and two match values; a single shared control word turns each timer on, picks its clock (every cycle or an external tick-enable pulse), gates its overflow flag and chooses its count direction. A timer counting up flags overflow when it wraps from all ones to zero. A timer counting down returns to its reload value after reaching zero, and that return is flagged as an overflow too.

Every match and overflow event sets a sticky bit in a shared status word. A mask word with inverted sense (a set bit blocks the source) selects which status bits drive the single registered interrupt line. Software reaches all registers through a plain read/write port addressed by byte offset. Reads are combinational.

Top module: `tmr_block`

## Requirements
- R1: Timer n (n = 0..2) has count, reload, match1 and match2 at byte offsets 0x10*n + 0x0, 0x4, 0x8 and 0xC. Control is at 0x30, status at 0x34 and mask at 0x38. Reads of 0x3C or of any misaligned address (addr_i[1:0] != 0) return 0, and writes to them are ignored. Reset clears every register except the mask.
- R2: Control bit 3n enables timer n, bit 3n+1 selects its tick-enable clock, bit 3n+2 enables its overflow flag, and bit 9+n sets its direction (1 = up, 0 = down). Only bits 11:0 are stored.
- R3: One cycle after a timer's enable bit goes from 0 to 1, its count equals its reload value.
- R4: An enabled timer steps on every clock when its clock-select bit is 0, and only on cycles with tick_i high when the bit is 1. A disabled timer holds its count.
- R5: An up-counting timer that steps from 0xFFFFFFFF to 0 sets status bit 3n+2 on that edge, but only if its overflow-enable bit is set.
- R6: A down-counting timer that steps while at 0 loads its reload value, and sets status bit 3n+2 if its overflow-enable bit is set.
- R7: While timer n is enabled and its count equals match1 (match2), status bit 3n (3n+1) is set.
- R8: Status bits are sticky. A write to 0x34 clears each bit written as 0 and keeps each bit written as 1. An event in the same cycle as the clear leaves its bit set.
- R9: The mask holds 9 bits and resets to 0x1FF. irq_o is the OR of the status bits whose mask bit is 0, registered once, so it follows a status or mask change by one cycle.
- R10: A write to a count register replaces the count on that edge, taking priority over stepping and enable loading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | External tick-enable for timers whose clock-select bit is set |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
On every cycle, the assertions check how the counter updates: the load on enable, holding while disabled or while waiting for a tick, the up step, the reload of a down counter at zero and the priority of software count writes. They also check that status bits stay set until cleared, that an event wins over a clear in the same cycle, and that the interrupt stays low when everything is masked. Only the bench scenarios can show the register map and the control-bit layout, the exact edge on which an overflow lands after a preset count, match flags that follow from programmed match values, and the one-cycle lag of irq_o after a mask or status change.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NT      = 3;
  localparam int EVT_PER = 3;
  localparam int ST_W    = NT * EVT_PER;
  localparam int CTRL_W  = 4 * NT;
  localparam int DIR_LSB = 3 * NT;
  localparam int ADDR_W  = 6;

  localparam logic [3:0] W_CTRL = 4'd12;
  localparam logic [3:0] W_STAT = 4'd13;
  localparam logic [3:0] W_MASK = 4'd14;

  typedef enum logic [1:0] {R_CNT = 2'd0, R_RLD = 2'd1, R_M1 = 2'd2, R_M2 = 2'd3} tmr_reg_e;
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         sel_i,
  input  logic         up_i,
  input  logic         ovf_en_i,
  input  logic         tick_i,
  input  logic [3:0]   we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] rld_o,
  output logic [W-1:0] m1_o,
  output logic [W-1:0] m2_o,
  output logic [2:0]   evt_o
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONES = '1;

  logic [W-1:0] cnt_q, rld_q, m1_q, m2_q;
  logic         en_d_q;
  logic         start, step, wrap;

  assign start = en_i & ~en_d_q;
  assign step  = en_i & en_d_q & (~sel_i | tick_i);
  assign wrap  = up_i ? (cnt_q == ONES) : (cnt_q == ZERO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_d_q <= 1'b0;
      cnt_q  <= '0;
      rld_q  <= '0;
      m1_q   <= '0;
      m2_q   <= '0;
    end else begin
      en_d_q <= en_i;
      if (we_i[tmr_pkg::R_RLD]) rld_q <= wdata_i;
      if (we_i[tmr_pkg::R_M1])  m1_q  <= wdata_i;
      if (we_i[tmr_pkg::R_M2])  m2_q  <= wdata_i;
      // software write > enable load > step
      if (we_i[tmr_pkg::R_CNT])  cnt_q <= wdata_i;
      else if (start)            cnt_q <= rld_q;
      else if (step) begin
        if (up_i)                cnt_q <= cnt_q + 1'b1;
        else if (wrap)           cnt_q <= rld_q;
        else                     cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign evt_o[0] = en_i & (cnt_q == m1_q);
  assign evt_o[1] = en_i & (cnt_q == m2_q);
  assign evt_o[2] = step & wrap & ovf_en_i & ~we_i[tmr_pkg::R_CNT];

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
  assign m1_o  = m1_q;
  assign m2_o  = m2_q;

  p_start_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !we_i[0]) |=> (cnt_q == $past(rld_q)));
  p_hold_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !we_i[0]) |=> $stable(cnt_q));
  p_tick_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && en_d_q && sel_i && !tick_i && !we_i[0]) |=> $stable(cnt_q));
  p_up_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && en_d_q && (!sel_i || tick_i) && up_i && !we_i[0]) |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_down_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && en_d_q && (!sel_i || tick_i) && !up_i && cnt_q == ZERO && !we_i[0]) |=> (cnt_q == $past(rld_q)));
  p_cnt_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i[0] |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int NS = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NS-1:0] evt_i,
  input  logic          st_we_i,
  input  logic          mask_we_i,
  input  logic [NS-1:0] wdata_i,
  output logic [NS-1:0] status_o,
  output logic [NS-1:0] mask_o,
  output logic          irq_o
);
  logic [NS-1:0] status_q, mask_q;
  logic          irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '1;
      irq_q    <= 1'b0;
    end else begin
      // new events win over a same-cycle clear
      status_q <= (st_we_i ? (status_q & wdata_i) : status_q) | evt_i;
      if (mask_we_i) mask_q <= wdata_i;
      irq_q <= |(status_q & ~mask_q);
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = irq_q;

  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_we_i |=> ((status_q & $past(status_q)) == $past(status_q)));
  p_evt_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i)));
  p_all_masked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q) |=> !irq_q);
endmodule

// File: rtl/tmr_block.sv
module tmr_block #(
  parameter int CNT_W = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       tick_i,
  input  logic                       we_i,
  input  logic [tmr_pkg::ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]           wdata_i,
  output logic [CNT_W-1:0]           rdata_o,
  output logic                       irq_o
);
  import tmr_pkg::*;

  logic [3:0]        word;
  logic              aligned;
  logic [CTRL_W-1:0] ctrl_q;
  logic [ST_W-1:0]   evt, status, mask;
  logic [CNT_W-1:0]  cnt [NT];
  logic [CNT_W-1:0]  rld [NT];
  logic [CNT_W-1:0]  m1  [NT];
  logic [CNT_W-1:0]  m2  [NT];

  assign word    = addr_i[5:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (we_i && aligned && word == W_CTRL) ctrl_q <= wdata_i[CTRL_W-1:0];
  end

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    logic [3:0] ch_we;
    for (genvar r = 0; r < 4; r++) begin : g_we
      assign ch_we[r] = we_i && aligned && (word == 4'(4 * t + r));
    end
    tmr_chan #(.W(CNT_W)) i_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (ctrl_q[3*t]),
      .sel_i    (ctrl_q[3*t+1]),
      .ovf_en_i (ctrl_q[3*t+2]),
      .up_i     (ctrl_q[DIR_LSB+t]),
      .tick_i   (tick_i),
      .we_i     (ch_we),
      .wdata_i  (wdata_i),
      .cnt_o    (cnt[t]),
      .rld_o    (rld[t]),
      .m1_o     (m1[t]),
      .m2_o     (m2[t]),
      .evt_o    (evt[EVT_PER*t +: EVT_PER])
    );
  end

  tmr_irq #(.NS(ST_W)) i_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt),
    .st_we_i   (we_i && aligned && word == W_STAT),
    .mask_we_i (we_i && aligned && word == W_MASK),
    .wdata_i   (wdata_i[ST_W-1:0]),
    .status_o  (status),
    .mask_o    (mask),
    .irq_o     (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      if (word < W_CTRL) begin
        case (tmr_reg_e'(word[1:0]))
          R_CNT:   rdata_o = cnt[word[3:2]];
          R_RLD:   rdata_o = rld[word[3:2]];
          R_M1:    rdata_o = m1[word[3:2]];
          default: rdata_o = m2[word[3:2]];
        endcase
      end else if (word == W_CTRL) begin
        rdata_o = CNT_W'(ctrl_q);
      end else if (word == W_STAT) begin
        rdata_o = CNT_W'(status);
      end else if (word == W_MASK) begin
        rdata_o = CNT_W'(mask);
      end
    end
  end
endmodule

// File: tb/test_tmr_block.sv
`timescale 1ns/1ps
module test_tmr_block;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  tmr_block i_tmr_block (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  localparam int NV = 15;
  localparam logic [5:0]  V_ADDR [NV] = '{6'h04, 6'h08, 6'h0C, 6'h14, 6'h18, 6'h1C, 6'h24, 6'h28,
                                          6'h2C, 6'h30, 6'h30, 6'h38, 6'h38, 6'h3C, 6'h05};
  localparam logic [31:0] V_WR [NV] = '{32'h11111111, 32'h22222222, 32'h33333333, 32'hA5A5A5A5,
                                        32'h5A5A5A5A, 32'h0F0F0F0F, 32'hF0F0F0F0, 32'h12345678,
                                        32'h87654321, 32'hFFFFFFFF, 32'h00000000, 32'hFFFFFFFF,
                                        32'h000000AA, 32'hDEADBEEF, 32'hCAFEF00D};
  localparam logic [31:0] V_EXP [NV] = '{32'h11111111, 32'h22222222, 32'h33333333, 32'hA5A5A5A5,
                                         32'h5A5A5A5A, 32'h0F0F0F0F, 32'hF0F0F0F0, 32'h12345678,
                                         32'h87654321, 32'h00000FFF, 32'h00000000, 32'h000001FF,
                                         32'h000000AA, 32'h00000000, 32'h00000000};

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v, x;
    do_reset();

    // R1 R2 R9: register map readback
    for (int i = 0; i < NV; i++) begin
      wr(V_ADDR[i], V_WR[i]);
      rd(V_ADDR[i], v);
      check("R1/R2/R9 map", v, V_EXP[i]);
    end

    do_reset();
    rd(6'h30, v); check("R1 reset ctrl", v, 32'h0);
    rd(6'h38, v); check("R9 reset mask", v, 32'h1FF);
    rd(6'h34, v); check("R1 reset status", v, 32'h0);
    rd(6'h00, v); check("R1 reset count", v, 32'h0);
    check("R9 reset irq", {31'b0, irq}, 32'h0);

    // R3 R4: timer 0 up, every clock
    wr(6'h04, 32'd100);
    wr(6'h30, 32'h201);
    @(negedge clk); rd(6'h00, v); check("R3 load on enable", v, 32'd100);
    repeat (5) @(negedge clk);
    rd(6'h00, v); check("R4 up every clock", v, 32'd105);

    // R10: count write overrides stepping
    wr(6'h00, 32'd500);
    rd(6'h00, v); check("R10 count write", v, 32'd500);
    @(negedge clk); rd(6'h00, v); check("R10 step after write", v, 32'd501);

    // R4: disabled timer holds
    wr(6'h30, 32'h0);
    rd(6'h00, x);
    repeat (3) @(negedge clk);
    rd(6'h00, v); check("R4 hold when disabled", v, x);

    // R4: tick-enable clock
    wr(6'h04, 32'd10);
    wr(6'h30, 32'h203);
    @(negedge clk);
    repeat (3) @(negedge clk);
    rd(6'h00, v); check("R4 no tick holds", v, 32'd10);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    rd(6'h00, v); check("R4 one tick one step", v, 32'd11);
    @(negedge clk);
    rd(6'h00, v); check("R4 tick low again holds", v, 32'd11);

    // R6 R7: timer 0 down with reload 3, match1 = 2
    wr(6'h30, 32'h0);
    wr(6'h34, 32'h0);
    wr(6'h04, 32'd3);
    wr(6'h08, 32'd2);
    wr(6'h0C, 32'd50);
    wr(6'h30, 32'h005);
    repeat (4) @(negedge clk);
    rd(6'h00, v); check("R6 down reaches zero", v, 32'd0);
    rd(6'h34, v); check("R6 no overflow before reload", v & 32'h4, 32'h0);
    @(negedge clk);
    rd(6'h00, v); check("R6 reload after zero", v, 32'd3);
    repeat (2) @(negedge clk);
    rd(6'h34, v); check("R6/R7 status down", v & 32'h7, 32'h5);

    // R5: timer 1 up overflow after 3 ticks
    wr(6'h30, 32'h0);
    wr(6'h34, 32'h0);
    wr(6'h14, 32'hFFFFFFFD);
    wr(6'h30, 32'h428);
    repeat (3) @(negedge clk);
    rd(6'h10, v); check("R5 count at top", v, 32'hFFFFFFFF);
    rd(6'h34, v); check("R5 no flag before wrap", v & 32'h20, 32'h0);
    @(negedge clk);
    rd(6'h10, v); check("R5 wrapped to zero", v, 32'h0);
    rd(6'h34, v); check("R5 overflow flag", v & 32'h20, 32'h20);
    check("R9 masked irq low", {31'b0, irq}, 32'h0);

    // R9: unmask overflow of timer 1
    wr(6'h38, 32'h1DF);
    check("R9 irq lags mask", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R9 irq after unmask", {31'b0, irq}, 32'h1);

    // R8: sticky status and clear
    wr(6'h34, 32'hFFFFFFFF);
    rd(6'h34, v); check("R8 write ones keeps", v & 32'h20, 32'h20);
    wr(6'h34, ~32'h20);
    rd(6'h34, v); check("R8 clear one bit", v & 32'h38, 32'h18);
    @(negedge clk);
    check("R8/R9 irq drops after clear", {31'b0, irq}, 32'h0);

    // R5: overflow enable clear on timer 2
    wr(6'h30, 32'h0);
    wr(6'h34, 32'h0);
    wr(6'h24, 32'hFFFFFFFE);
    wr(6'h28, 32'd100);
    wr(6'h2C, 32'd200);
    wr(6'h30, 32'h840);
    repeat (6) @(negedge clk);
    rd(6'h20, v); check("R2 timer 2 counts up", v, 32'd3);
    rd(6'h34, v); check("R5 no flag without enable", v, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule